// File: doc/BRIEF.md
# Paged Address Translation Map

This block sits between a network controller and its packet buffer memory. It turns a 24-bit controller-side address into a physical location. The location is made of a page frame number, a byte offset within a 1024-byte page, a byte-lane swap indication and a choice between on-board memory and an expansion bus. The translation uses a 1024-slot page map. A host loads and inspects the map through a 16-bit word port.

Each translation request also carries one 16-bit data word. The block returns that word with its bytes exchanged when the selected map entry calls for little-endian controller order. The host's own buffer accesses present their addresses on the same request port, so both sides see memory through one mapping. Only address bits 19:0 take part. The top nibble is dropped, so the controller's fixed boot pointer at 0xFFFFF4 always resolves through the last slot. Software must program that slot to cover the boot pointer.

Top module: `xlat_pagemap`

## Requirements
- R1: The response offset `rsp_offset` equals request address bits 9:0, whatever the map holds.
- R2: The map slot is selected by request address bits 19:10. Different slots return their own entries independently.
- R3: Address bits 23:20 have no effect on the result, and address 0xFFFFF4 resolves through slot 1023 with offset 0x3F4.
- R4: Map entry bit 15 selects byte order. When it is 0 (controller order), `rsp_swap` is 1 and `rsp_data` is the request data with its two bytes exchanged. When it is 1 (host order), `rsp_swap` is 0 and `rsp_data` equals the request data.
- R5: Map entry bit 13 is returned as `rsp_xbus`: 1 selects the expansion bus and 0 selects on-board memory.
- R6: `rsp_frame` equals map entry bits 11:0. `rsp_oor` is 1 exactly when a valid response selects on-board memory with a frame of 256 or more. It is never 1 for an expansion-bus target.
- R7: A request accepted on one rising edge gives `rsp_valid` and its fields after exactly that edge, one cycle of latency. Back-to-back requests give back-to-back responses.
- R8: A map write takes effect for translation requests presented on the cycle after it. A request presented in the same cycle as a write to its slot sees the previous entry.
- R9: A host map read returns the full 16-bit entry, including bits 14 and 12, which have no effect on translation. The entry appears on `map_rdata` with `map_rd_valid` high one cycle after `map_rd_en`.
- R10: While reset is asserted, `rsp_valid`, `rsp_oor` and `map_rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_wr_en | input | 1 | Host writes `map_wdata` into slot `map_idx` |
| map_rd_en | input | 1 | Host reads slot `map_idx` |
| map_idx | input | 10 | Map slot for host access |
| map_wdata | input | 16 | Entry value to write |
| map_rdata | output | 16 | Entry value read back |
| map_rd_valid | output | 1 | `map_rdata` holds a read result |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 24 | Address to translate |
| req_data | input | 16 | Data word carried with the request |
| rsp_valid | output | 1 | Response fields are valid |
| rsp_frame | output | 12 | Physical page frame |
| rsp_offset | output | 10 | Byte offset within the page |
| rsp_swap | output | 1 | Bytes exchanged (controller order) |
| rsp_xbus | output | 1 | Target is the expansion bus |
| rsp_oor | output | 1 | On-board frame out of range |
| rsp_data | output | 16 | Data word after optional byte exchange |

## Verification
Several checks run on every cycle. They cover the offset pass-through, the one-cycle response timing, the byte exchange of the data word against the swap indication, and the rule that the out-of-range flag is raised exactly for on-board frames of 256 or more and stays low when idle. Other behaviour needs the map contents and so only the bench scenarios can show it. This covers which slot a given address selects, that the top nibble aliases, and where the boot pointer address lands. It also covers read-before-write ordering when a write and a lookup meet in one cycle, and the readback of bits that do not affect translation.

// File: rtl/xlat_pagemap_pkg.sv
package xlat_pagemap_pkg;
  localparam int ENTRY_W    = 16;
  localparam int ORDER_BIT  = 15;  // 1: host order, 0: controller order
  localparam int TARGET_BIT = 13;  // 1: expansion bus, 0: on-board

  function automatic logic [15:0] lane_exchange(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/pagemap_store.sv
module pagemap_store #(
  parameter int SLOT_W  = 10,
  parameter int ENTRY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [SLOT_W-1:0]  host_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               rd_valid,
  input  logic [SLOT_W-1:0]  lk_idx,
  output logic [ENTRY_W-1:0] lk_entry
);
  localparam int SLOTS = 1 << SLOT_W;

  logic [ENTRY_W-1:0] slots_q [SLOTS];
  logic [ENTRY_W-1:0] rd_data_d;
  logic               rd_valid_d;

  // storage array, no reset (RAM-like)
  always_ff @(posedge clk) begin
    if (wr_en) slots_q[host_idx] <= wr_data;
  end

  assign lk_entry = slots_q[lk_idx];

  always_comb begin
    rd_valid_d = rd_en;
    rd_data_d  = rd_en ? slots_q[host_idx] : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_valid_d;
      rd_data  <= rd_data_d;
    end
  end
endmodule

// File: rtl/xlat_stage.sv
module xlat_stage
  import xlat_pagemap_pkg::*;
#(
  parameter int OFFS_W        = 10,
  parameter int FRAME_W       = 12,
  parameter int DATA_W        = 16,
  parameter int ONBOARD_PAGES = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [OFFS_W-1:0]  req_offset,
  input  logic [DATA_W-1:0]  req_data,
  input  logic [ENTRY_W-1:0] entry,
  output logic               rsp_valid,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic [OFFS_W-1:0]  rsp_offset,
  output logic               rsp_swap,
  output logic               rsp_xbus,
  output logic               rsp_oor,
  output logic [DATA_W-1:0]  rsp_data
);
  logic [FRAME_W-1:0] frame_d;
  logic               swap_d, xbus_d, oor_d;
  logic [DATA_W-1:0]  data_d;
  logic [1:0]         unused_entry_bits;

  assign unused_entry_bits = {entry[14], entry[12]};

  always_comb begin
    frame_d = entry[FRAME_W-1:0];
    swap_d  = ~entry[ORDER_BIT];
    xbus_d  = entry[TARGET_BIT];
    oor_d   = req_valid && !xbus_d &&
              (32'(frame_d) >= ONBOARD_PAGES);
    data_d  = swap_d ? lane_exchange(req_data) : req_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_oor    <= 1'b0;
      rsp_frame  <= '0;
      rsp_offset <= '0;
      rsp_swap   <= 1'b0;
      rsp_xbus   <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_oor   <= oor_d;
      if (req_valid) begin
        rsp_frame  <= frame_d;
        rsp_offset <= req_offset;
        rsp_swap   <= swap_d;
        rsp_xbus   <= xbus_d;
        rsp_data   <= data_d;
      end
    end
  end
endmodule

// File: rtl/xlat_pagemap.sv
module xlat_pagemap
  import xlat_pagemap_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int OFFS_W        = 10,
  parameter int SLOT_W        = 10,
  parameter int FRAME_W       = 12,
  parameter int DATA_W        = 16,
  parameter int ONBOARD_PAGES = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               map_wr_en,
  input  logic               map_rd_en,
  input  logic [SLOT_W-1:0]  map_idx,
  input  logic [15:0]        map_wdata,
  output logic [15:0]        map_rdata,
  output logic               map_rd_valid,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_data,
  output logic               rsp_valid,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic [OFFS_W-1:0]  rsp_offset,
  output logic               rsp_swap,
  output logic               rsp_xbus,
  output logic               rsp_oor,
  output logic [DATA_W-1:0]  rsp_data
);
  localparam int USED_W = OFFS_W + SLOT_W;

  logic [SLOT_W-1:0]       slot;
  logic [ENTRY_W-1:0]      entry;
  logic [ADDR_W-USED_W-1:0] unused_high_addr;

  assign slot             = req_addr[USED_W-1:OFFS_W];
  assign unused_high_addr = req_addr[ADDR_W-1:USED_W];

  pagemap_store #(.SLOT_W(SLOT_W), .ENTRY_W(ENTRY_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (map_wr_en),
    .rd_en    (map_rd_en),
    .host_idx (map_idx),
    .wr_data  (map_wdata),
    .rd_data  (map_rdata),
    .rd_valid (map_rd_valid),
    .lk_idx   (slot),
    .lk_entry (entry)
  );

  xlat_stage #(
    .OFFS_W(OFFS_W), .FRAME_W(FRAME_W), .DATA_W(DATA_W),
    .ONBOARD_PAGES(ONBOARD_PAGES)
  ) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_offset (req_addr[OFFS_W-1:0]),
    .req_data   (req_data),
    .entry      (entry),
    .rsp_valid  (rsp_valid),
    .rsp_frame  (rsp_frame),
    .rsp_offset (rsp_offset),
    .rsp_swap   (rsp_swap),
    .rsp_xbus   (rsp_xbus),
    .rsp_oor    (rsp_oor),
    .rsp_data   (rsp_data)
  );
endmodule

// File: rtl/xlat_pagemap_chk.sv
module xlat_pagemap_chk #(
  parameter int ADDR_W        = 24,
  parameter int OFFS_W        = 10,
  parameter int FRAME_W       = 12,
  parameter int DATA_W        = 16,
  parameter int ONBOARD_PAGES = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               map_rd_en,
  input logic               map_rd_valid,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [DATA_W-1:0]  req_data,
  input logic               rsp_valid,
  input logic [FRAME_W-1:0] rsp_frame,
  input logic [OFFS_W-1:0]  rsp_offset,
  input logic               rsp_swap,
  input logic               rsp_xbus,
  input logic               rsp_oor,
  input logic [DATA_W-1:0]  rsp_data
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    rsp_valid == $past(req_valid)); // R7

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    rsp_valid |-> rsp_offset == $past(req_addr[OFFS_W-1:0])); // R1

  AST_SWAP_DATA: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rsp_valid && rsp_swap) |-> rsp_data == {$past(req_data[7:0]), $past(req_data[15:8])}); // R4

  AST_KEEP_DATA: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rsp_valid && !rsp_swap) |-> rsp_data == $past(req_data)); // R4

  AST_OOR_ONLY_ONBOARD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_oor |-> (rsp_valid && !rsp_xbus && (32'(rsp_frame) >= ONBOARD_PAGES))); // R6

  AST_OOR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_xbus && (32'(rsp_frame) >= ONBOARD_PAGES)) |-> rsp_oor); // R6

  AST_READ_TIMING: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    map_rd_valid == $past(map_rd_en)); // R9

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!rsp_valid && !rsp_oor && !map_rd_valid); // R10
    end
  end
endmodule

bind xlat_pagemap xlat_pagemap_chk #(
  .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .FRAME_W(FRAME_W),
  .DATA_W(DATA_W), .ONBOARD_PAGES(ONBOARD_PAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .map_rd_en(map_rd_en), .map_rd_valid(map_rd_valid),
  .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
  .rsp_valid(rsp_valid), .rsp_frame(rsp_frame), .rsp_offset(rsp_offset),
  .rsp_swap(rsp_swap), .rsp_xbus(rsp_xbus), .rsp_oor(rsp_oor), .rsp_data(rsp_data)
);

// File: tb/xlat_pagemap_test.sv
`timescale 1ns/1ps
module xlat_pagemap_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        map_wr_en, map_rd_en;
  logic [9:0]  map_idx;
  logic [15:0] map_wdata, map_rdata;
  logic        map_rd_valid;
  logic        req_valid;
  logic [23:0] req_addr;
  logic [15:0] req_data;
  logic        rsp_valid, rsp_swap, rsp_xbus, rsp_oor;
  logic [11:0] rsp_frame;
  logic [9:0]  rsp_offset;
  logic [15:0] rsp_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [15:0] model [1024];

  typedef struct packed {
    logic [11:0] frame;
    logic [9:0]  offset;
    logic        swap;
    logic        xbus;
    logic        oor;
    logic [15:0] data;
  } rsp_t;

  rsp_t  exp_q [$];
  string tag_q [$];

  always #2 clk = ~clk;

  xlat_pagemap uut (
    .clk(clk), .rst_n(rst_n),
    .map_wr_en(map_wr_en), .map_rd_en(map_rd_en), .map_idx(map_idx),
    .map_wdata(map_wdata), .map_rdata(map_rdata), .map_rd_valid(map_rd_valid),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_frame(rsp_frame), .rsp_offset(rsp_offset),
    .rsp_swap(rsp_swap), .rsp_xbus(rsp_xbus), .rsp_oor(rsp_oor), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic rsp_t expect_of(input logic [15:0] e, input logic [23:0] a, input logic [15:0] d);
    rsp_t r;
    r.frame  = e[11:0];
    r.offset = a[9:0];
    r.swap   = ~e[15];
    r.xbus   = e[13];
    r.oor    = !e[13] && (e[11:0] >= 12'd256);
    r.data   = e[15] ? d : {d[7:0], d[15:8]};
    return r;
  endfunction

  // driver
  task automatic translate(input logic [23:0] a, input logic [15:0] d, input string tag);
    @(negedge clk);
    map_wr_en = 1'b0; map_rd_en = 1'b0;
    req_valid = 1'b1; req_addr = a; req_data = d;
    exp_q.push_back(expect_of(model[a[19:10]], a, d));
    tag_q.push_back(tag);
  endtask

  task automatic quiet();
    @(negedge clk);
    req_valid = 1'b0; map_wr_en = 1'b0; map_rd_en = 1'b0;
  endtask

  task automatic map_write(input logic [9:0] idx, input logic [15:0] v);
    @(negedge clk);
    req_valid = 1'b0; map_rd_en = 1'b0;
    map_wr_en = 1'b1; map_idx = idx; map_wdata = v;
    model[idx] = v;
    @(negedge clk);
    map_wr_en = 1'b0;
  endtask

  task automatic map_read(input logic [9:0] idx, input string tag);
    @(negedge clk);
    req_valid = 1'b0; map_wr_en = 1'b0;
    map_rd_en = 1'b1; map_idx = idx;
    @(negedge clk);
    map_rd_en = 1'b0;
    check(map_rd_valid === 1'b1 && map_rdata === model[idx], tag,
          {47'd0, map_rd_valid, map_rdata}, {47'd0, 1'b1, model[idx]});
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected response", 64'd1, 64'd0);
      end else begin
        rsp_t  e;
        rsp_t  a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {rsp_frame, rsp_offset, rsp_swap, rsp_xbus, rsp_oor, rsp_data};
        check(a === e, t, 64'(a), 64'(e));
      end
    end else if (rst_n && !rsp_valid) begin
      check(!rsp_oor, "R6 oor while idle", {63'd0, rsp_oor}, 64'd0);
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    map_wr_en = 0; map_rd_en = 0; map_idx = '0; map_wdata = '0;
    req_valid = 0; req_addr = '0; req_data = '0;
    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b0, "R10 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check(rsp_oor === 1'b0, "R10 rsp_oor", {63'd0, rsp_oor}, 64'd0);
    check(map_rd_valid === 1'b0, "R10 map_rd_valid", {63'd0, map_rd_valid}, 64'd0);
    rst_n = 1'b1;

    map_write(10'd0,    16'h8005);
    map_write(10'd1,    16'h0010);
    map_write(10'd2,    16'h2345);
    map_write(10'd3,    16'h0100);
    map_write(10'd4,    16'h80FF);
    map_write(10'd5,    16'h0001);
    map_write(10'd6,    16'h5ABC);
    map_write(10'd1023, 16'h8077);
    map_write(10'd700,  16'hA9FF);

    map_read(10'd0, "R9 slot0");
    map_read(10'd6, "R9 unused bits kept");
    map_read(10'd1023, "R9 slot1023");

    translate(24'h000123, 16'h1234, "R1 offset slot0");
    translate(24'h0007FF, 16'hABCD, "R4 swap slot1");
    translate(24'h000800, 16'h00FF, "R5 xbus slot2");
    translate(24'h000C10, 16'h5555, "R6 oor frame256");
    translate(24'h001000, 16'hBEEF, "R6 frame255 in range");
    quiet();
    translate(24'h0AF3FF, 16'hC3A5, "R2 slot700 xbus big frame");
    translate(24'h000000, 16'h0102, "R2 slot0 back");
    quiet();
    translate(24'hFFFFF4, 16'h9876, "R3 boot pointer");
    translate(24'h0FFFF4, 16'h9876, "R3 alias 0x0F");
    translate(24'hA00400, 16'h4321, "R3 alias slot1");
    quiet();

    // R8: write and lookup of slot5 in the same cycle
    @(negedge clk);
    req_valid = 1'b1; req_addr = 24'h001420; req_data = 16'h7788;
    exp_q.push_back(expect_of(model[5], 24'h001420, 16'h7788));
    tag_q.push_back("R8 same cycle sees old");
    map_wr_en = 1'b1; map_idx = 10'd5; map_wdata = 16'hA0C0;
    model[5] = 16'hA0C0;
    translate(24'h001421, 16'h7788, "R8 next cycle sees new");
    quiet();

    translate(24'h000C00, 16'h0000, "R7 back-to-back a");
    translate(24'h000001, 16'hFFFF, "R7 back-to-back b");
    quiet();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7 all responses seen", 64'(exp_q.size()), 64'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule